// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the target side of a two-wire serial bus fronting a 256-byte, byte-wide memory. It samples SCL and SDA with the system clock through two-flop synchronizers and detects START and STOP conditions in those samples. It answers its select byte and drives SDA low through an open-drain enable. The memory is a register array inside the block.

A controller writes one byte, or up to a 16-byte page, after a word address. The data is collected in a page buffer and is committed to the array on the closing STOP. A timed write cycle then starts, and the block ignores its select byte for the whole of that cycle, so the controller can poll for completion.

Reads start at the current address, or at a chosen address when a write preamble is followed by a repeated START. Reads continue for as long as the controller acknowledges each byte. A single inhibit input refuses data bytes. A repeated START drops any data that is still pending, so only a STOP commits a write.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The select byte, sent MSB first, is the preamble 1010, then strap[2:0] with the MSB first, then the direction bit (1 = read, 0 = write). The block acknowledges a matching select byte and does not acknowledge any other select byte.
- R2: The block acknowledges the word address and each accepted write data byte by holding SDA low during the ninth SCL clock.
- R3: Address bits [7:4] select a page and bits [3:0] advance after each data byte, wrapping inside the page, so a seventeenth byte lands on the first one.
- R4: A STOP that closes a write with at least one accepted data byte commits that data. `busy` rises on the third system clock edge after SDA rises for the STOP and stays high for exactly WR_CYCLES clocks. A STOP that closes no accepted data leaves `busy` low.
- R5: While `busy` is high, a select byte for either direction gets no acknowledge.
- R6: A read with no preceding address returns the byte after the last one accessed. The address wraps from 0xFF to 0x00.
- R7: A write preamble carrying only a word address, followed by a repeated START and a read select byte, makes the read start at that address.
- R8: A read continues with the next byte while the controller acknowledges each byte, and ends at a NACK. The address wraps at the end of memory.
- R9: The block changes its SDA drive only while SCL is low. A falling SDA edge with SCL high is a START, and a rising SDA edge with SCL high is a STOP.
- R10: After reset every memory byte is 0xFF, `busy` is low and SDA is released.
- R11: When `wr_inhibit` is high as a data byte completes, that byte gets no acknowledge, the pending write is discarded and no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap | input | 3 | Device address straps compared with select bits [3:1] |
| wr_inhibit | input | 1 | Refuse write data bytes while high |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Each bus event reaches the logic two clocks after the pin moves, and the block responds on the third clock. An acknowledge or data bit is therefore valid a few clocks after the SCL falling edge. The bench samples SDA halfway through the SCL high phase, well clear of that delay. `busy` is predicted by a reference counter that loads on the third clock after the STOP's SDA rise and is compared with the port on every falling clock edge. The bench also checks every change of the SDA drive against the SCL level the bench itself is driving at that moment.

// File: rtl/i2c_eeprom_slave.sv
`timescale 1ns/1ps
module i2c_eeprom_slave #(
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wr_inhibit,
  output logic       sda_oe,
  output logic       busy
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {IDLE, DEV, WADDR, WDATA, READ} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh, ptr, tx;
  logic       ackph, mack, wpend;
  logic [15:0] pmask;
  logic [7:0] pbuf [16];
  logic [7:0] mem [256];
  logic [CW-1:0] bcnt;

  wire scl       = scl_s[1];
  wire sda       = sda_s[1];
  wire start_det = scl & scl_q & sda_q & ~sda;
  wire stop_det  = scl & scl_q & ~sda_q & sda;
  wire rise      = scl & ~scl_q;
  wire fall      = ~scl & scl_q;
  wire byte_end  = fall & ~ackph & (cnt == 4'd8);
  wire dev_hit   = (sh[7:1] == {4'b1010, strap});
  wire dev_done  = byte_end & (st == DEV);
  wire data_done = byte_end & (st == WDATA);

  assign busy = (bcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i}; sda_s <= {sda_s[0], sda_i};
      scl_q <= scl; sda_q <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sh <= '0; ptr <= '0; tx <= '0;
      ackph <= 1'b0; mack <= 1'b0; wpend <= 1'b0; pmask <= '0;
      sda_oe <= 1'b0; bcnt <= '0;
      for (int i = 0; i < 16; i++) pbuf[i] <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
    end else begin
      if (stop_det && wpend) bcnt <= CW'(WR_CYCLES);
      else if (busy)         bcnt <= bcnt - 1'b1;

      if (start_det) begin
        st <= DEV; cnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0;
        wpend <= 1'b0; pmask <= '0;
      end else if (stop_det) begin
        st <= IDLE; ackph <= 1'b0; sda_oe <= 1'b0;
        wpend <= 1'b0; pmask <= '0;
        if (wpend)
          for (int i = 0; i < 16; i++)
            if (pmask[i]) mem[{ptr[7:4], 4'(i)}] <= pbuf[i];
      end else if (st != IDLE) begin
        if (rise) begin
          if (ackph) mack <= ~sda;
          else if (cnt < 4'd8) begin
            sh  <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end
        end else if (fall) begin
          if (ackph) begin
            ackph <= 1'b0; cnt <= '0; sda_oe <= 1'b0;
            if (st == READ) begin
              if (mack) begin
                tx <= mem[ptr]; sda_oe <= ~mem[ptr][7]; ptr <= ptr + 8'd1;
              end else st <= IDLE;
            end
          end else if (cnt == 4'd8) begin
            case (st)
              DEV: begin
                if (dev_hit && !busy) begin
                  sda_oe <= 1'b1; ackph <= 1'b1;
                  if (sh[0]) begin st <= READ; mack <= 1'b1; end
                  else st <= WADDR;
                end else st <= IDLE;
              end
              WADDR: begin
                ptr <= sh; sda_oe <= 1'b1; ackph <= 1'b1; st <= WDATA;
              end
              WDATA: begin
                if (wr_inhibit) begin
                  st <= IDLE; wpend <= 1'b0; pmask <= '0;
                end else begin
                  sda_oe <= 1'b1; ackph <= 1'b1; wpend <= 1'b1;
                  pbuf[ptr[3:0]]  <= sh;
                  pmask[ptr[3:0]] <= 1'b1;
                  ptr[3:0]        <= ptr[3:0] + 4'd1;
                end
              end
              READ: begin sda_oe <= 1'b0; ackph <= 1'b1; end
              default: st <= IDLE;
            endcase
          end else if (st == READ) begin
            sda_oe <= ~tx[~cnt[2:0]];
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_slave_chk.sv
`timescale 1ns/1ps
module eeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic sda_oe,
  input logic busy,
  input logic stop_det,
  input logic dev_done,
  input logic data_done,
  input logic wr_inhibit
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl); // R9
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R4
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_done && busy) |=> !sda_oe); // R5
  AST_INHIBIT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && wr_inhibit) |=> !sda_oe); // R11
  AST_NO_DRIVE_IDLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det) |=> !sda_oe); // R9
endmodule

bind i2c_eeprom_slave eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .sda_oe(sda_oe), .busy(busy),
  .stop_det(stop_det), .dev_done(dev_done), .data_done(data_done),
  .wr_inhibit(wr_inhibit)
);

// File: tb/tb_i2c_eeprom_slave.sv
`timescale 1ns/1ps
module tb_i2c_eeprom_slave;
  localparam int W = 400;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, inh = 1'b0;
  logic sda_oe, busy;
  wire  sda_line = m_sda & ~sda_oe;

  i2c_eeprom_slave #(.WR_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap(STRAP), .wr_inhibit(inh), .sda_oe(sda_oe), .busy(busy));

  int checks = 0, errors = 0, cyc = 0, stop_at = -1, mbusy = 0;
  bit stop_pend = 0;
  logic oe_prev = 1'b0;
  logic [7:0] mm [256];
  logic [7:0] mptr = 8'h00;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) mbusy = 0;
    else if (cyc == stop_at && stop_pend) mbusy = W;
    else if (mbusy > 0) mbusy--;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 busy", busy, mbusy > 0);
      if (sda_oe !== oe_prev) chk("R9 drive change with SCL low", m_scl, 0);
    end
    oe_prev = sda_oe;
  end

  task automatic hc(); repeat (Q) @(negedge clk); endtask
  task automatic start_c();
    m_sda = 1; hc(); m_scl = 1; hc(); m_sda = 0; hc(); m_scl = 0; hc();
  endtask
  task automatic stop_c(input bit pend);
    m_sda = 0; hc(); m_scl = 1; hc();
    m_sda = 1; stop_at = cyc + 3; stop_pend = pend; hc(); hc();
  endtask
  task automatic bit_w(input bit b);
    m_sda = b; hc(); m_scl = 1; hc(); hc(); m_scl = 0; hc();
  endtask
  task automatic bit_r(output bit b);
    m_sda = 1; hc(); m_scl = 1; hc(); b = sda_line; hc(); m_scl = 0; hc();
  endtask
  task automatic wr_byte(input logic [7:0] d, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(b); ack = ~b;
  endtask
  task automatic rd_byte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin bit_r(b); d[i] = b; end
    bit_w(~ack);
  endtask

  task automatic read_n(input int n, input string r);
    bit a; logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      rd_byte(d, k < n - 1);
      chk(r, d, mm[mptr]);
      mptr = mptr + 8'd1;
    end
    stop_c(0);
  endtask

  task automatic sel_read(input logic [7:0] addr, input int n, input string r);
    bit a;
    start_c(); wr_byte({4'hA, STRAP, 1'b0}, a); chk("R1 write select ack", a, 1);
    wr_byte(addr, a); chk("R2 address ack", a, 1);
    start_c(); wr_byte({4'hA, STRAP, 1'b1}, a); chk("R7 read select ack", a, 1);
    mptr = addr;
    read_n(n, r);
  endtask

  task automatic cur_read(input int n, input string r);
    bit a;
    start_c(); wr_byte({4'hA, STRAP, 1'b1}, a); chk("R1 read select ack", a, 1);
    read_n(n, r);
  endtask

  task automatic page_write(input logic [7:0] addr, input int n, input logic [7:0] base);
    bit a; logic [3:0] lo;
    start_c(); wr_byte({4'hA, STRAP, 1'b0}, a); chk("R1 write select ack", a, 1);
    wr_byte(addr, a); chk("R2 address ack", a, 1);
    lo = addr[3:0];
    for (int k = 0; k < n; k++) begin
      wr_byte(base + 8'(k), a); chk("R2 data ack", a, 1);
      mm[{addr[7:4], lo}] = base + 8'(k);
      lo = lo + 4'd1;
    end
    mptr = {addr[7:4], lo};
    stop_c(1);
  endtask

  task automatic wait_ready();
    bit a;
    start_c(); wr_byte({4'hA, STRAP, 1'b0}, a); stop_c(0);
    chk("R5 select refused while busy", a, 0);
    for (int t = 0; t < 20 && !a; t++) begin
      start_c(); wr_byte({4'hA, STRAP, 1'b0}, a); stop_c(0);
    end
    chk("R5 select accepted after write cycle", a, 1);
  endtask

  initial begin
    bit a;
    for (int i = 0; i < 256; i++) mm[i] = 8'hFF;
    repeat (5) @(negedge clk);
    chk("R10 busy low in reset", busy, 0);
    chk("R10 SDA released in reset", sda_oe, 0);
    rst_n = 1; hc();

    sel_read(8'h10, 1, "R10 erased byte");

    page_write(8'h05, 1, 8'hA5);
    wait_ready();
    sel_read(8'h05, 1, "R7 selective read");

    start_c(); wr_byte({4'hA, ~STRAP, 1'b0}, a); stop_c(0);
    chk("R1 strap mismatch refused", a, 0);
    start_c(); wr_byte({4'hB, STRAP, 1'b1}, a); stop_c(0);
    chk("R1 preamble mismatch refused", a, 0);

    page_write(8'h2E, 18, 8'h30);
    wait_ready();
    cur_read(2, "R6 current address after page write");
    sel_read(8'h20, 16, "R3 page wrap contents");

    page_write(8'hFF, 1, 8'h3C); wait_ready();
    page_write(8'h00, 1, 8'h11); wait_ready();
    sel_read(8'hFE, 4, "R8 sequential read wrap");
    cur_read(1, "R6 current address after read");
    sel_read(8'hFF, 1, "R6 last byte");
    cur_read(1, "R6 wrap to zero");

    inh = 1;
    start_c(); wr_byte({4'hA, STRAP, 1'b0}, a); chk("R11 select ack", a, 1);
    wr_byte(8'h40, a); chk("R11 address ack", a, 1);
    wr_byte(8'h5A, a); chk("R11 inhibited data refused", a, 0);
    stop_c(0);
    inh = 0;
    hc(); hc();
    chk("R11 no write cycle", busy, 0);
    sel_read(8'h40, 1, "R11 byte unchanged");

    hc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule